// File: doc/BRIEF.md
# Virtual-Channel ADC Conversion Controller

This block sits between a word-addressed processor bus and a 12-bit successive-approximation converter core. Software fills in a table of sixteen virtual channels. Each entry names one of eight physical analog inputs and carries an enable bit. To start a conversion, software sets the virtual channel's bit in a force register. The controller takes the pending requests one at a time and drives the converter through a start pulse and a channel select. When the busy line drops, the controller stores the 12-bit result in that virtual channel's data register and sets both a fresh-data flag and an interrupt status bit.

A power-down bit in the configuration register is passed straight through to the converter. While it is set, forced requests are discarded. Requests on disabled channels are also discarded. A typical driver clears power-down, maps and enables a channel, forces it, waits out the worst-case conversion time, reads the data register and checks the fresh-data flag, then sets power-down again.

Top module: `vchan_adc_ctrl`

## Requirements
- R1: After reset, every mapped register reads zero, `cnv_start` is low and `cnv_pdown` is low.
- R2: The control register of virtual channel n sits at word 48+n. It keeps a physical input select in bits [2:0] and an enable in bit 15. All other bits read zero.
- R3: Writing 1 to bit n of the force register (word 13) requests a conversion on virtual channel n. The conversion is started with `cnv_sel` equal to that channel's physical input select.
- R4: Pending requests are served one at a time, lowest virtual channel first. A force bit reads back as 1 until its conversion is handed to the converter, and as 0 afterwards.
- R5: When a conversion on channel n completes, the data register at word 64+n holds the result in bits [11:0] and reads 1 in bit 31, the fresh-data flag.
- R6: A completed conversion on channel n sets bit n of the interrupt status register (word 0). Writing 1 to a status bit clears only that bit.
- R7: Reading a data register clears its fresh-data flag and leaves the result bits unchanged.
- R8: A forced request on a channel whose enable bit is clear is discarded. It clears its force bit but starts no conversion and sets neither the fresh-data flag nor the status bit.
- R9: Bit 3 of the configuration register (word 16) is the power-down bit and drives `cnv_pdown`. A request made while it is set is discarded, as in R8. Writing zero to the register restores normal conversions.
- R10: Reads of any word that is not mapped return zero, and writes to such words change no register.
- R11: `cnv_start` is a single-cycle pulse and is issued only while `cnv_busy` is low. Only one conversion is in flight at a time.
- R12: The result is taken from `cnv_result` in the cycle in which `cnv_busy` is seen low after having been high. This works for converter latencies from 1 to 21 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and the converter interface |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| cnv_pdown | output | 1 | Power-down request to the converter |
| cnv_start | output | 1 | Single-cycle conversion start |
| cnv_sel | output | 3 | Physical input select, valid while `cnv_start` is high |
| cnv_busy | input | 1 | Converter busy |
| cnv_result | input | 12 | Conversion result, valid when busy falls |

## Verification
The bench drives every virtual channel through a converter model whose latency is swept from 21 cycles down to 1. It checks the captured result against a value that encodes the select and the conversion sequence number. A design that sampled the result one cycle late, or before busy rose, would return a stale word.

A burst of scattered force bits checks the service order and the force bits clearing one at a time; a design that served requests in any other order would log selects in a different sequence. Further checks cover disabled and powered-down requests, which must leave the data, status and converter untouched, and partial write-1-to-clear of the status register. The last group writes all ones to unmapped words just beside each mapped region, which catches a decoder that aliases neighbouring words.

// File: rtl/vca_pkg.sv
// Package: shared constants and types for the virtual-channel ADC controller.
// Assumes word addressing; the offsets and bit positions below are what
// software decodes, so they are fixed here rather than per instance.
package vca_pkg;
    localparam int DATA_W          = 32;
    localparam int WORD_IRQ_STAT   = 0;
    localparam int WORD_FORCE      = 13;
    localparam int WORD_CFG        = 16;
    localparam int WORD_CTRL_BASE  = 48;
    localparam int WORD_DATA_BASE  = 64;
    localparam int CTRL_EN_BIT     = 15;
    localparam int CFG_PD_BIT      = 3;
    localparam int DATA_UPD_BIT    = 31;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_CONV
    } sq_state_e;
endpackage

// File: rtl/vca_lowest_set.sv
// Module: lowest-index picker. Returns the index of the lowest set bit of
// req_i and whether any bit is set. Purely combinational.
// Assumes N fits in IDX_W bits.
module vca_lowest_set #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    // Any request present.
    assign any_o = |req_i;
endmodule

// File: rtl/vca_sequencer.sv
// Module: conversion sequencer. Picks the lowest pending virtual channel,
// discards it when disabled or powered down, otherwise pulses start with
// the mapped physical select, waits for busy to rise and then fall, and
// reports the result. Assumes the converter raises busy within a few
// cycles of start and holds the result valid when busy falls.
module vca_sequencer import vca_pkg::*; #(
    parameter int NUM_VCH = 16,
    parameter int SEL_W   = 3,
    parameter int RES_W   = 12,
    parameter int IDX_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_VCH-1:0]             pend_i,
    input  logic [NUM_VCH-1:0]             en_i,
    input  logic [NUM_VCH-1:0][SEL_W-1:0]  sel_i,
    input  logic                           pdown_i,
    output logic [NUM_VCH-1:0]             pend_clr_o,
    output logic                           cnv_start_o,
    output logic [SEL_W-1:0]               cnv_sel_o,
    input  logic                           cnv_busy_i,
    input  logic [RES_W-1:0]               cnv_result_i,
    output logic                           done_vld_o,
    output logic [IDX_W-1:0]               done_idx_o,
    output logic [RES_W-1:0]               done_res_o
);
    sq_state_e         state_q;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic              launch_ok;
    logic [IDX_W-1:0]  cur_q;
    logic              start_q;
    logic [SEL_W-1:0]  sel_q;

    vca_lowest_set #(.N(NUM_VCH), .IDX_W(IDX_W)) u_pick (
        .req_i (pend_i),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // The picked request may go to the converter only if enabled and powered.
    assign launch_ok = pick_any && en_i[pick_idx] && !pdown_i;

    // Retire the picked force bit whenever the sequencer is idle.
    always_comb begin
        pend_clr_o = '0;
        if (state_q == SQ_IDLE && pick_any) pend_clr_o = NUM_VCH'(1) << pick_idx;
    end

    // Handshake state machine: idle -> arm (start pulse) -> conv (busy high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            start_q <= 1'b0;
            sel_q   <= '0;
            cur_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (launch_ok) begin
                        start_q <= 1'b1;
                        sel_q   <= sel_i[pick_idx];
                        cur_q   <= pick_idx;
                        state_q <= SQ_ARM;
                    end
                end
                SQ_ARM: begin
                    start_q <= 1'b0;
                    if (cnv_busy_i) state_q <= SQ_CONV;
                end
                SQ_CONV: begin
                    if (!cnv_busy_i) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Converter-side outputs and completion report.
    assign cnv_start_o = start_q;
    assign cnv_sel_o   = sel_q;
    assign done_vld_o  = (state_q == SQ_CONV) && !cnv_busy_i;
    assign done_idx_o  = cur_q;
    assign done_res_o  = cnv_result_i;

    // R11
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start_o |=> !cnv_start_o);
    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start_o |-> !cnv_busy_i);
    // R9
    start_pdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start_o |-> !$past(pdown_i));
    // R12
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld_o |-> $past(cnv_busy_i));
endmodule

// File: rtl/vca_regfile.sv
// Module: word-addressed register file. Holds the per-channel control
// table, the force (pending) bits, the power-down bit, the interrupt status
// and the per-channel result/fresh-data registers. Reads are registered
// and appear on bus_rdata one cycle after the strobe. Assumes NUM_VCH is a
// power of two and that both channel blocks fit the address space.
module vca_regfile import vca_pkg::*; #(
    parameter int NUM_VCH = 16,
    parameter int SEL_W   = 3,
    parameter int RES_W   = 12,
    parameter int ADDR_W  = 7,
    parameter int IDX_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_req,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_VCH-1:0]             pend_o,
    output logic [NUM_VCH-1:0]             en_o,
    output logic [NUM_VCH-1:0][SEL_W-1:0]  sel_o,
    output logic                           pdown_o,
    input  logic [NUM_VCH-1:0]             pend_clr_i,
    input  logic                           done_vld_i,
    input  logic [IDX_W-1:0]               done_idx_i,
    input  logic [RES_W-1:0]               done_res_i
);
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(WORD_IRQ_STAT);
    localparam logic [ADDR_W-1:0] A_FORCE    = ADDR_W'(WORD_FORCE);
    localparam logic [ADDR_W-1:0] A_CFG      = ADDR_W'(WORD_CFG);
    localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(WORD_CTRL_BASE);
    localparam logic [ADDR_W-1:0] A_CTRL_END = ADDR_W'(WORD_CTRL_BASE + NUM_VCH);
    localparam logic [ADDR_W-1:0] A_DATA     = ADDR_W'(WORD_DATA_BASE);
    localparam logic [ADDR_W-1:0] A_DATA_END = ADDR_W'(WORD_DATA_BASE + NUM_VCH);

    logic                 wr_en, rd_en;
    logic                 hit_stat, hit_force, hit_cfg, hit_ctrl, hit_data, any_hit;
    logic [IDX_W-1:0]     ctrl_idx, data_idx;
    logic [NUM_VCH-1:0]   pend_q, stat_q, done_1h, stat_clr, force_set;
    logic                 pdown_q;
    logic                 en_q  [NUM_VCH];
    logic [SEL_W-1:0]     sel_q [NUM_VCH];
    logic [RES_W-1:0]     res_q [NUM_VCH];
    logic                 upd_q [NUM_VCH];
    logic [DATA_W-1:0]    rmux;
    logic [DATA_W-1:0]    rdata_q;

    // Address decode.
    assign wr_en     = bus_req && bus_we;
    assign rd_en     = bus_req && !bus_we;
    assign hit_stat  = (bus_addr == A_STAT);
    assign hit_force = (bus_addr == A_FORCE);
    assign hit_cfg   = (bus_addr == A_CFG);
    assign hit_ctrl  = (bus_addr >= A_CTRL) && (bus_addr < A_CTRL_END);
    assign hit_data  = (bus_addr >= A_DATA) && (bus_addr < A_DATA_END);
    assign any_hit   = hit_stat || hit_force || hit_cfg || hit_ctrl || hit_data;
    assign ctrl_idx  = IDX_W'(bus_addr - A_CTRL);
    assign data_idx  = IDX_W'(bus_addr - A_DATA);

    // Per-bit set/clear vectors for the pending and status registers.
    assign done_1h   = done_vld_i ? (NUM_VCH'(1) << done_idx_i) : '0;
    assign stat_clr  = (wr_en && hit_stat)  ? bus_wdata[NUM_VCH-1:0] : '0;
    assign force_set = (wr_en && hit_force) ? bus_wdata[NUM_VCH-1:0] : '0;

    // Force bits: set by the bus, retired by the sequencer; a new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr_i) | force_set;
    end

    // Interrupt status: write-1-to-clear, completion sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | done_1h;
    end

    // Configuration: only the power-down bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pdown_q <= 1'b0;
        else if (wr_en && hit_cfg)   pdown_q <= bus_wdata[CFG_PD_BIT];
    end

    for (genvar g = 0; g < NUM_VCH; g++) begin : g_vch
        // Control entry g: physical select and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g] <= '0;
                en_q[g]  <= 1'b0;
            end else if (wr_en && hit_ctrl && ctrl_idx == IDX_W'(g)) begin
                sel_q[g] <= bus_wdata[SEL_W-1:0];
                en_q[g]  <= bus_wdata[CTRL_EN_BIT];
            end
        end

        // Result entry g: capture on completion, flag cleared by a read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
                upd_q[g] <= 1'b0;
            end else if (done_vld_i && done_idx_i == IDX_W'(g)) begin
                res_q[g] <= done_res_i;
                upd_q[g] <= 1'b1;
            end else if (rd_en && hit_data && data_idx == IDX_W'(g)) begin
                upd_q[g] <= 1'b0;
            end
        end

        assign en_o[g]  = en_q[g];
        assign sel_o[g] = sel_q[g];

        // R7
        upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && hit_data && data_idx == IDX_W'(g) &&
             !(done_vld_i && done_idx_i == IDX_W'(g))) |=> !upd_q[g]);
    end

    // Read multiplexer; unmapped words fall through to zero.
    always_comb begin
        rmux = '0;
        if (hit_stat) begin
            rmux[NUM_VCH-1:0] = stat_q;
        end else if (hit_force) begin
            rmux[NUM_VCH-1:0] = pend_q;
        end else if (hit_cfg) begin
            rmux[CFG_PD_BIT] = pdown_q;
        end else if (hit_ctrl) begin
            rmux[CTRL_EN_BIT] = en_q[ctrl_idx];
            rmux[SEL_W-1:0]   = sel_q[ctrl_idx];
        end else if (hit_data) begin
            rmux[DATA_UPD_BIT] = upd_q[data_idx];
            rmux[RES_W-1:0]    = res_q[data_idx];
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rmux;
        else            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pend_o    = pend_q;
    assign pdown_o   = pdown_q;

    // R6
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld_i |=> ((stat_q & $past(done_1h)) == $past(done_1h)));
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (bus_rdata == '0));
endmodule

// File: rtl/vchan_adc_ctrl.sv
// Module: top of the virtual-channel ADC conversion controller. Joins the
// register file to the conversion sequencer and exposes the bus and the
// digital converter interface. Assumes a converter that answers a start
// pulse with busy and presents its result when busy falls.
module vchan_adc_ctrl import vca_pkg::*; #(
    parameter int  NUM_VCH = 16,
    parameter int  NUM_PHY = 8,
    parameter int  RES_W   = 12,
    parameter int  ADDR_W  = 7,
    localparam int SEL_W   = $clog2(NUM_PHY),
    localparam int IDX_W   = $clog2(NUM_VCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cnv_pdown,
    output logic              cnv_start,
    output logic [SEL_W-1:0]  cnv_sel,
    input  logic              cnv_busy,
    input  logic [RES_W-1:0]  cnv_result
);
    logic [NUM_VCH-1:0]            pend, en, pend_clr;
    logic [NUM_VCH-1:0][SEL_W-1:0] sel;
    logic                          pdown;
    logic                          done_vld;
    logic [IDX_W-1:0]              done_idx;
    logic [RES_W-1:0]              done_res;

    vca_regfile #(
        .NUM_VCH(NUM_VCH), .SEL_W(SEL_W), .RES_W(RES_W),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pend_o     (pend),
        .en_o       (en),
        .sel_o      (sel),
        .pdown_o    (pdown),
        .pend_clr_i (pend_clr),
        .done_vld_i (done_vld),
        .done_idx_i (done_idx),
        .done_res_i (done_res)
    );

    vca_sequencer #(
        .NUM_VCH(NUM_VCH), .SEL_W(SEL_W), .RES_W(RES_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend),
        .en_i         (en),
        .sel_i        (sel),
        .pdown_i      (pdown),
        .pend_clr_o   (pend_clr),
        .cnv_start_o  (cnv_start),
        .cnv_sel_o    (cnv_sel),
        .cnv_busy_i   (cnv_busy),
        .cnv_result_i (cnv_result),
        .done_vld_o   (done_vld),
        .done_idx_o   (done_idx),
        .done_res_o   (done_res)
    );

    // Power-down goes straight to the converter.
    assign cnv_pdown = pdown;
endmodule

// File: tb/tb_vchan_adc_ctrl.sv
`timescale 1ns/1ps
module tb_vchan_adc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnv_pdown, cnv_start, cnv_busy;
    logic [2:0]  cnv_sel;
    logic [11:0] cnv_result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vchan_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnv_pdown(cnv_pdown), .cnv_start(cnv_start), .cnv_sel(cnv_sel),
        .cnv_busy(cnv_busy), .cnv_result(cnv_result)
    );

    // Converter model: busy for 'lat' cycles, result = {sel, start number}.
    int          lat = 5;
    int          cnt = 0;
    int          nstart = 0;
    logic [11:0] pend_res = '0;
    logic [2:0]  log_sel [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            cnv_busy   <= 1'b0;
            cnv_result <= '0;
            cnt        <= 0;
            nstart     <= 0;
        end else if (cnv_busy) begin
            if (cnt <= 1) begin
                cnv_busy   <= 1'b0;
                cnv_result <= pend_res;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (cnv_start) begin
            cnv_busy <= 1'b1;
            cnt      <= lat;
            pend_res <= {cnv_sel, 9'(nstart)};
            log_sel[nstart % 64] <= cnv_sel;
            nstart   <= nstart + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 7'(a);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] expd(input int s, input int k, input bit flag);
        return (flag ? 32'h8000_0000 : 32'h0) | 32'((s & 7) << 9) | 32'(k & 511);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        int base;
        int s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state of every mapped word and of the converter outputs
        chk("R1 start", {31'b0, cnv_start}, 0);
        chk("R1 pdown", {31'b0, cnv_pdown}, 0);
        rd(0, v);  chk("R1 status", v, 0);
        rd(13, v); chk("R1 force", v, 0);
        rd(16, v); chk("R1 config", v, 0);
        for (int i = 0; i < 16; i++) begin
            rd(48 + i, v); chk("R1 ctrl", v, 0);
            rd(64 + i, v); chk("R1 data", v, 0);
        end

        // R2: control fields keep select [2:0] and enable bit 15 only
        for (int i = 0; i < 16; i++) begin
            wr(48 + i, 32'hFFFF_FFFF); rd(48 + i, v); chk("R2 all ones", v, 32'h0000_8007);
            wr(48 + i, 32'h7FFF_7FF8); rd(48 + i, v); chk("R2 other bits", v, 0);
        end

        // R3 R5 R6 R7 R12: each channel, latency swept 21 down to 6
        k = 0;
        for (int i = 0; i < 16; i++) begin
            s = (i * 3 + 1) % 8;
            lat = 21 - i;
            wr(48 + i, 32'h8000 | 32'(s));
            wr(13, 32'(1) << i);
            idle(32);
            chk("R3 select", {29'b0, log_sel[k]}, 32'(s));
            rd(64 + i, v); chk("R5 R12 data", v, expd(s, k, 1));
            rd(64 + i, v); chk("R7 flag clear", v, expd(s, k, 0));
            rd(0, v); chk("R6 status set", v, 32'(1) << i);
            wr(0, 32'(1) << i);
            rd(0, v); chk("R6 status w1c", v, 0);
            k++;
        end

        // R12: shortest latency
        lat = 1;
        wr(48 + 9, 32'h8003);
        wr(13, 32'h0200);
        idle(12);
        rd(64 + 9, v); chk("R12 lat1", v, expd(3, k, 1));
        wr(0, 32'hFFFF);
        k++;

        // R4: scattered burst served lowest channel first
        lat = 15;
        for (int i = 0; i < 16; i++) wr(48 + i, 32'h8000 | 32'(i % 8));
        wr(13, 32'hA5A5);
        idle(3);
        rd(13, v); chk("R4 force partial", v, 32'hA5A4);
        idle(8 * 25);
        rd(13, v); chk("R4 force drained", v, 0);
        rd(0, v); chk("R6 burst status", v, 32'hA5A5);
        base = k;
        for (int i = 0; i < 16; i++) begin
            if (((32'hA5A5 >> i) & 1) != 0) begin
                chk("R4 order", {29'b0, log_sel[k]}, 32'(i % 8));
                rd(64 + i, v); chk("R4 data", v, expd(i % 8, k, 1));
                k++;
            end
        end
        chk("R4 count", 32'(nstart), 32'(base + 8));
        wr(0, 32'h0000_0021);
        rd(0, v); chk("R6 partial w1c", v, 32'hA584);
        wr(0, 32'hFFFF);

        // R8: disabled channel request discarded
        wr(48 + 5, 32'h0000_0003);
        base = nstart;
        wr(13, 32'h0020);
        idle(40);
        chk("R8 no start", 32'(nstart), 32'(base));
        rd(13, v); chk("R8 force cleared", v, 0);
        rd(0, v); chk("R8 no status", v, 0);
        rd(64 + 5, v); chk("R8 no flag", v & 32'h8000_0000, 0);

        // R9: power-down blocks conversions, then recovers
        wr(16, 32'hFFFF_FFFF);
        rd(16, v); chk("R9 config", v, 32'h8);
        chk("R9 pdown pin", {31'b0, cnv_pdown}, 1);
        wr(13, 32'h0040);
        idle(40);
        chk("R9 no start", 32'(nstart), 32'(base));
        rd(0, v); chk("R9 no status", v, 0);
        rd(13, v); chk("R9 force cleared", v, 0);
        wr(16, 32'h0);
        chk("R9 pdown off", {31'b0, cnv_pdown}, 0);
        wr(13, 32'h0040);
        idle(40);
        rd(0, v); chk("R9 resumed status", v, 32'h0040);
        rd(64 + 6, v); chk("R9 resumed data", v, expd(6, k, 1));
        k++;
        wr(0, 32'hFFFF);

        // R10: unmapped words beside each region read zero, writes ignored
        foreach (v[i]) begin end
        for (int j = 0; j < 8; j++) begin
            int a;
            a = (j == 0) ? 1 : (j == 1) ? 12 : (j == 2) ? 14 : (j == 3) ? 15 :
                (j == 4) ? 17 : (j == 5) ? 47 : (j == 6) ? 80 : 127;
            wr(a, 32'hFFFF_FFFF);
            rd(a, v); chk("R10 unmapped", v, 0);
        end
        idle(30);
        rd(0, v);  chk("R10 status untouched", v, 0);
        rd(16, v); chk("R10 config untouched", v, 0);
        rd(13, v); chk("R10 force untouched", v, 0);
        chk("R10 no start", 32'(nstart), 32'(k));

        // R11: single conversion at a time is also covered by the burst count
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule